// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides, for an eight-input interrupt controller, whether the processor should be interrupted and which line should be granted. It holds three 8-bit registers: pending requests, the mask and the in-service set. Each request line is captured either on its rising edge or as a level. A line is in level mode when the global level setting is on or when that line's own level bit is set.

Priority is circular. The line at priority index p is (p + base) mod 8, and index 0 is the most urgent. The base is a register. It is loaded through a configuration port and can also advance automatically when a grant is made in auto-EOI mode. The resolver finds the best unmasked pending request and the best in-service level. It raises its interrupt output only when the request strictly outranks everything in service. Special-mask mode and fully nested operation on a master can each remove entries from the in-service set before that comparison.

The surrounding controller grants a line by pulsing the acknowledge strobe together with the line number. Register access and cascading are handled outside the block. The mode settings arrive here as plain inputs.

Top module: `prio_irq_resolver`

## Requirements
- R1: After reset, the pending, last-level, mask and in-service registers and the priority base are zero, and `irqOut` and `winLine` are 0.
- R2: For a line in edge mode, a low-to-high change on `reqLines[i]` sets pending bit i. Holding the line high does not set the bit again after it has been cleared. Dropping the line does not clear the pending bit.
- R3: For a line in level mode (`levelAll` = 1 or `levelSel[i]` = 1), pending bit i follows the sampled level of `reqLines[i]` every cycle.
- R4: A pending line whose mask bit is 1 never raises `irqOut`. The mask register loads `maskData` on a cycle with `maskWe` = 1.
- R5: The priority base loads `baseData` when `baseWe` = 1. Among the candidates, the winner is the first line met in the order base, base+1, …, base+7 (mod 8).
- R6: `irqOut` rises only when the winning candidate's priority index is strictly lower than that of the best in-service line. An equal index does not raise it.
- R7: With `specialMask` = 1, in-service lines whose mask bit is set are left out of the in-service comparison.
- R8: With `fullyNested` = 1 and `isMaster` = 1, in-service line 2 is left out of the in-service comparison. With `isMaster` = 0, line 2 is not left out.
- R9: An acknowledge clears the granted pending bit only for an edge-mode line. With `autoEoi` = 0, the acknowledge also sets the granted in-service bit.
- R10: An acknowledge with `autoEoi` = 1 sets no in-service bit. If `rotateOnAutoEoi` = 1 as well, the base becomes (`ackLine` + 1) mod 8.
- R11: `irqOut` and `winLine` are registered and recomputed from the current state every cycle. A request captured at one clock edge shows at the next edge. `winLine` is 0 whenever `irqOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqLines | input | 8 | Interrupt request lines |
| levelAll | input | 1 | Puts all lines in level mode |
| levelSel | input | 8 | Per-line level mode select |
| maskWe | input | 1 | Mask register load strobe |
| maskData | input | 8 | New mask value |
| baseWe | input | 1 | Priority base load strobe |
| baseData | input | 3 | New priority base |
| autoEoi | input | 1 | Acknowledge does not set in-service |
| rotateOnAutoEoi | input | 1 | Rotate the base on an auto-EOI acknowledge |
| specialMask | input | 1 | Masked lines leave the in-service comparison |
| fullyNested | input | 1 | Fully nested operation |
| isMaster | input | 1 | This unit is a cascade master |
| ackStrobe | input | 1 | Acknowledge pulse |
| ackLine | input | 3 | Line being acknowledged |
| irqOut | output | 1 | Registered interrupt request |
| winLine | output | 3 | Registered winning line number |

## Verification
The assertions assume that a base load and an auto-EOI rotation do not fall in the same cycle, because the load takes precedence there. They also assume the level settings are held steady around the edges they watch. The bench acknowledges only the line that `winLine` has just reported and pulses each strobe for exactly one cycle. It changes mode and level settings only while the lines involved are quiet. It returns to reset between scenarios, so in-service bits that are never retired cannot carry over from one scenario into the next.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int DefLines = 8;
  localparam int DefCascadeLine = 2;

  typedef struct packed {
    logic setIsr;
    logic clrEdgeReq;
    logic rotBase;
    logic loadBase;
    logic loadMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/prio_find.sv
module prio_find #(
  parameter int NumLines = 8,
  localparam int IdxW = $clog2(NumLines)
) (
  input  logic [NumLines-1:0] vec,
  input  logic [IdxW-1:0]     base,
  output logic [IdxW:0]       idx
);
  logic [NumLines-1:0] rotated;

  for (genvar p = 0; p < NumLines; p++) begin : g_rot
    logic [IdxW-1:0] lineSel;
    assign lineSel = IdxW'(p) + base;
    assign rotated[p] = vec[lineSel];
  end

  always_comb begin
    idx = (IdxW+1)'(NumLines);
    for (int p = NumLines - 1; p >= 0; p--) begin
      if (rotated[p]) idx = (IdxW+1)'(p);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic         ackStrobe,
  input  logic         autoEoi,
  input  logic         rotateOnAutoEoi,
  input  logic         maskWe,
  input  logic         baseWe,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.clrEdgeReq = ackStrobe;
    strobes.setIsr     = ackStrobe & ~autoEoi;
    strobes.rotBase    = ackStrobe & autoEoi & rotateOnAutoEoi & ~baseWe;
    strobes.loadBase   = baseWe;
    strobes.loadMask   = maskWe;
  end
endmodule

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NumLines = DefLines,
  parameter int CascadeLine = DefCascadeLine,
  localparam int IdxW = $clog2(NumLines)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumLines-1:0] reqLines,
  input  logic                levelAll,
  input  logic [NumLines-1:0] levelSel,
  input  logic [NumLines-1:0] maskData,
  input  logic [IdxW-1:0]     baseData,
  input  logic                specialMask,
  input  logic                fullyNested,
  input  logic                isMaster,
  input  logic [IdxW-1:0]     ackLine,
  input  ctrlStrobes_t        strobes,
  output logic                irqOut,
  output logic [IdxW-1:0]     winLine
);
  logic [NumLines-1:0] irr, lastLvl, isr, imr;
  logic [IdxW-1:0]     base;
  logic [NumLines-1:0] lineLevel, ackOh, irrNext, isrNext;
  logic [NumLines-1:0] cand, svc, svcKeep, nestKeep;
  logic [IdxW:0]       candIdx, svcIdx;
  logic                pastValid;

  assign lineLevel = levelSel | {NumLines{levelAll}};
  assign ackOh     = NumLines'(1) << ackLine;

  // Per-line capture: level lines track the pin, edge lines latch a rise
  always_comb begin
    for (int i = 0; i < NumLines; i++) begin
      if (lineLevel[i]) begin
        irrNext[i] = reqLines[i];
      end else begin
        irrNext[i] = (irr[i] & ~(strobes.clrEdgeReq & ackOh[i]))
                   | (reqLines[i] & ~lastLvl[i]);
      end
    end
    isrNext = strobes.setIsr ? (isr | ackOh) : isr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr       <= '0;
      lastLvl   <= '0;
      isr       <= '0;
      imr       <= '0;
      base      <= '0;
      pastValid <= 1'b0;
    end else begin
      irr       <= irrNext;
      lastLvl   <= reqLines;
      isr       <= isrNext;
      pastValid <= 1'b1;
      if (strobes.loadMask) imr <= maskData;
      if (strobes.loadBase)     base <= baseData;
      else if (strobes.rotBase) base <= ackLine + 1'b1;
    end
  end

  // Resolution against the current in-service level
  assign cand     = irr & ~imr;
  assign svcKeep  = specialMask ? ~imr : '1;
  assign nestKeep = (fullyNested && isMaster) ? ~(NumLines'(1) << CascadeLine) : '1;
  assign svc      = isr & svcKeep & nestKeep;

  prio_find #(.NumLines(NumLines)) u_candFind (.vec(cand), .base(base), .idx(candIdx));
  prio_find #(.NumLines(NumLines)) u_svcFind  (.vec(svc),  .base(base), .idx(svcIdx));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut  <= 1'b0;
      winLine <= '0;
    end else begin
      irqOut  <= candIdx < svcIdx;
      winLine <= (candIdx < svcIdx) ? (candIdx[IdxW-1:0] + base) : '0;
    end
  end

  // Reported winner was an unmasked pending line one cycle earlier (R4)
  p_win_was_cand_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && irqOut) |-> (|($past(cand) & (NumLines'(1) << winLine))));

  // Level lines mirror the pin one cycle later (R3)
  p_level_tracks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(levelAll)) |-> (irr == $past(reqLines)));

  // Non-auto-EOI grant lands in the in-service set (R9)
  p_ack_sets_isr_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setIsr |=> isr[$past(ackLine)]);

  // Auto-EOI rotation moves the base just past the granted line (R10)
  p_rotate_base_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rotBase |=> (base == IdxW'($past(ackLine) + 1'b1)));

  // Edge lines only gain a request on a fresh rise (R2)
  for (genvar i = 0; i < NumLines; i++) begin : g_edgeChk
    p_edge_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && !$past(lineLevel[i]) && !$past(irr[i]) && irr[i])
        |-> $past(reqLines[i] && !lastLvl[i]));
  end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
  import prio_irq_pkg::*;
#(
  parameter int NumLines = DefLines,
  parameter int CascadeLine = DefCascadeLine,
  localparam int IdxW = $clog2(NumLines)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumLines-1:0] reqLines,
  input  logic                levelAll,
  input  logic [NumLines-1:0] levelSel,
  input  logic                maskWe,
  input  logic [NumLines-1:0] maskData,
  input  logic                baseWe,
  input  logic [IdxW-1:0]     baseData,
  input  logic                autoEoi,
  input  logic                rotateOnAutoEoi,
  input  logic                specialMask,
  input  logic                fullyNested,
  input  logic                isMaster,
  input  logic                ackStrobe,
  input  logic [IdxW-1:0]     ackLine,
  output logic                irqOut,
  output logic [IdxW-1:0]     winLine
);
  ctrlStrobes_t strobes;

  prio_irq_ctrl u_ctrl (
    .ackStrobe(ackStrobe), .autoEoi(autoEoi), .rotateOnAutoEoi(rotateOnAutoEoi),
    .maskWe(maskWe), .baseWe(baseWe), .strobes(strobes)
  );

  prio_irq_datapath #(.NumLines(NumLines), .CascadeLine(CascadeLine)) u_dp (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .levelAll(levelAll),
    .levelSel(levelSel), .maskData(maskData), .baseData(baseData),
    .specialMask(specialMask), .fullyNested(fullyNested), .isMaster(isMaster),
    .ackLine(ackLine), .strobes(strobes), .irqOut(irqOut), .winLine(winLine)
  );
endmodule

// File: tb/prio_irq_resolver_tb.sv
`timescale 1ns/1ps
module prio_irq_resolver_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] reqLines, levelSel, maskData;
  logic       levelAll, maskWe, baseWe, autoEoi, rotateOnAutoEoi;
  logic       specialMask, fullyNested, isMaster, ackStrobe;
  logic [2:0] baseData, ackLine;
  logic       irqOut;
  logic [2:0] winLine;
  int         nCmp = 0;
  int         nBad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_resolver u_dut (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .levelAll(levelAll),
    .levelSel(levelSel), .maskWe(maskWe), .maskData(maskData), .baseWe(baseWe),
    .baseData(baseData), .autoEoi(autoEoi), .rotateOnAutoEoi(rotateOnAutoEoi),
    .specialMask(specialMask), .fullyNested(fullyNested), .isMaster(isMaster),
    .ackStrobe(ackStrobe), .ackLine(ackLine), .irqOut(irqOut), .winLine(winLine)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    nCmp++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; reqLines = '0; levelSel = '0; maskData = '0; levelAll = 1'b0;
    maskWe = 1'b0; baseWe = 1'b0; baseData = '0; autoEoi = 1'b0;
    rotateOnAutoEoi = 1'b0; specialMask = 1'b0; fullyNested = 1'b0;
    isMaster = 1'b0; ackStrobe = 1'b0; ackLine = '0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic doAck(input int line);
    ackLine = 3'(line); ackStrobe = 1'b1;
    step(1);
    ackStrobe = 1'b0;
    step(1);
  endtask

  task automatic loadMask(input int m);
    maskData = 8'(m); maskWe = 1'b1; step(1); maskWe = 1'b0;
  endtask

  task automatic loadBase(input int b);
    baseData = 3'(b); baseWe = 1'b1; step(1); baseWe = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 irqOut after reset", irqOut, 0);
    chk("R1 winLine after reset", winLine, 0);
    step(3);
    chk("R1 idle stays quiet", irqOut, 0);
  endtask

  task automatic t_edge();
    doReset();
    reqLines[3] = 1'b1;
    step(1);
    chk("R11 one-cycle latency", irqOut, 0);
    step(1);
    chk("R2 edge raises irq", irqOut, 1);
    chk("R2 winner line 3", winLine, 3);
    doAck(3);
    chk("R9 ack drops irq", irqOut, 0);
    step(3);
    chk("R2 held line no retrigger", irqOut, 0);
    reqLines[3] = 1'b0; step(1);
    reqLines[3] = 1'b1; step(2);
    chk("R6 equal in-service blocks", irqOut, 0);
  endtask

  task automatic t_level();
    doReset();
    levelSel[6] = 1'b1;
    reqLines[6] = 1'b1; step(2);
    chk("R3 level raises irq", irqOut, 1);
    chk("R3 winner line 6", winLine, 6);
    reqLines[6] = 1'b0; step(2);
    chk("R3 level drop clears", irqOut, 0);
    reqLines[4] = 1'b1; step(1);
    reqLines[4] = 1'b0; step(2);
    chk("R2 edge request survives drop", irqOut, 1);
    chk("R2 winner line 4", winLine, 4);
    doReset();
    levelAll = 1'b1;
    reqLines[1] = 1'b1; step(2);
    chk("R3 global level raises", winLine, 1);
    reqLines[1] = 1'b0; step(2);
    chk("R3 global level drop clears", irqOut, 0);
  endtask

  task automatic t_mask();
    doReset();
    loadMask(8'h01);
    reqLines[0] = 1'b1; step(3);
    chk("R4 masked line silent", irqOut, 0);
    loadMask(8'h00); step(1);
    chk("R4 unmask raises", irqOut, 1);
    chk("R4 winner line 0", winLine, 0);
  endtask

  task automatic t_rotate();
    doReset();
    reqLines = 8'h42; step(2);
    chk("R5 base 0 picks line 1", winLine, 1);
    doReset();
    loadBase(5);
    reqLines = 8'h42; step(2);
    chk("R5 base 5 picks line 6", winLine, 6);
    doReset();
    loadBase(7);
    reqLines = 8'h41; step(2);
    chk("R5 base 7 picks line 0", winLine, 0);
  endtask

  task automatic t_inservice();
    doReset();
    reqLines[2] = 1'b1; step(2);
    doAck(2);
    reqLines[5] = 1'b1; step(2);
    chk("R6 lower request held off", irqOut, 0);
    reqLines[1] = 1'b1; step(2);
    chk("R6 higher request passes", irqOut, 1);
    chk("R6 winner line 1", winLine, 1);
  endtask

  task automatic t_special();
    doReset();
    reqLines[2] = 1'b1; step(2);
    doAck(2);
    reqLines[5] = 1'b1; step(2);
    loadMask(8'h04); step(1);
    chk("R7 plain mask keeps in-service", irqOut, 0);
    specialMask = 1'b1; step(2);
    chk("R7 special mask lifts line 2", irqOut, 1);
    chk("R7 winner line 5", winLine, 5);
  endtask

  task automatic t_nested();
    doReset();
    reqLines[2] = 1'b1; step(2);
    chk("R8 line 2 raises", winLine, 2);
    doAck(2);
    reqLines[2] = 1'b0; step(1);
    reqLines[2] = 1'b1; step(2);
    chk("R8 baseline blocked", irqOut, 0);
    fullyNested = 1'b1; step(2);
    chk("R8 non-master still blocked", irqOut, 0);
    isMaster = 1'b1; step(2);
    chk("R8 master ignores isr 2", irqOut, 1);
    chk("R8 winner line 2", winLine, 2);
  endtask

  task automatic t_autoEoi();
    doReset();
    autoEoi = 1'b1; levelSel[5] = 1'b1;
    reqLines[5] = 1'b1; step(2);
    doAck(5);
    chk("R9 level kept after ack", irqOut, 1);
    chk("R10 no in-service set", winLine, 5);
    doReset();
    autoEoi = 1'b1;
    reqLines[4] = 1'b1; step(2);
    doAck(4);
    chk("R9 edge cleared by ack", irqOut, 0);
  endtask

  task automatic t_autoRotate();
    doReset();
    autoEoi = 1'b1; rotateOnAutoEoi = 1'b1;
    reqLines[3] = 1'b1; step(2);
    chk("R10 line 3 raises", winLine, 3);
    doAck(3);
    reqLines[3] = 1'b0; step(1);
    reqLines[3] = 1'b1; step(2);
    chk("R10 no in-service after auto ack", irqOut, 1);
    chk("R10 line 3 again", winLine, 3);
    reqLines = 8'h2A; step(2);
    chk("R10 base moved to 4 picks 5", winLine, 5);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_level();
    t_mask();
    t_rotate();
    t_inservice();
    t_special();
    t_nested();
    t_autoEoi();
    t_autoRotate();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule